// File: doc/BRIEF.md
# Lost-Locality Score Throttling Unit

This block decides, every cycle, which wavefronts may send a load to the first-level data cache. It keeps one lost-locality score per wavefront. A score rises each time the wavefront misses on a line it recently owned, which the cache's victim-tag probe reports as a hit pulse carrying the wavefront ID. The score then falls by one point per cycle until it is back at a base value. Because of that decay, throttling eases off by itself once the thrashing stops.

The scores are ordered from the largest to the smallest, with equal scores ordered by ascending wavefront ID. A running sum is formed in that order. A wavefront whose running sum is above a cutoff is denied permission, but only in a cycle when it is trying to issue a load. The wavefronts that lose permission are therefore the ones with small scores. The wavefronts losing the most locality keep the cache to themselves. Non-load instructions are never gated. The issue arbiter ANDs the permission vector with its own ready vector.

Top module: `lls_throttle_unit`

## Requirements
- R1: After reset, and in the cycle after `launch_i` is high, every score equals `BASE`. In that state the running sum never exceeds the default cutoff (`NUM_WF*BASE`), so all permission bits are 1. `launch_i` takes precedence over a hit in the same cycle.
- R2: A hit pulse (`hit_vld_i`=1) adds `INC` to the score of wavefront `hit_wid_i`. Scores of other wavefronts are not affected by that pulse.
- R3: Every cycle, each score above `BASE` decreases by one. A score at `BASE` stays there. A hit and the decay in the same cycle apply as add first, then decrement.
- R4: Scores are ordered from the largest to the smallest. For equal scores, the lower wavefront ID comes first.
- R5: The running sum of wavefront i is its own score plus the scores of all wavefronts ordered before it. If that sum exceeds `CUTOFF` and `load_req_i[i]` is 1, then `can_issue_o[i]` is 0.
- R6: If `load_req_i[i]` is 0, then `can_issue_o[i]` is 1.
- R7: The wavefront first in the order is never throttled, even if its own score exceeds `CUTOFF`.
- R8: `can_issue_o` is combinational from the registered scores and `load_req_i`. It responds to a change of `load_req_i` in the same cycle.
- R9: The score add saturates at `CAP` before the decrement is applied. A wavefront hit repeatedly therefore holds at `CAP-1` and never exceeds `CAP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| launch_i | input | 1 | Kernel launch: all scores are set to the base value |
| hit_vld_i | input | 1 | Lost-locality hit pulse |
| hit_wid_i | input | $clog2(NUM_WF) | Wavefront ID of the hit pulse |
| load_req_i | input | NUM_WF | Wavefronts trying to issue a load this cycle |
| can_issue_o | output | NUM_WF | Per-wavefront load permission |

## Verification
The assertions assume that at most one hit pulse arrives per cycle. This is guaranteed by the port shape. They also assume that `hit_wid_i` always names an existing wavefront, which holds whenever `NUM_WF` is a power of two. The stimulus uses the default eight wavefronts. It draws IDs from the full three-bit range and sends hit pulses at a modest rate, so scores build up and also decay back to the base value. The stimulus includes:
- a burst of hits that drives one score to the cap;
- a wavefront that is first in the order with a score above the cutoff;
- a launch issued in the same cycle as a hit.

// File: rtl/lls_pkg.sv
package lls_pkg;

   // One cycle of score evolution for a single wavefront:
   // saturating add of the increment on a hit, then one-point decay
   // with the base value as a floor.
   function automatic int unsigned lls_step(
      input int unsigned cur,
      input bit          hit,
      input int unsigned inc,
      input int unsigned cap,
      input int unsigned base
   );
      int unsigned t;
      t = hit ? cur + inc : cur;
      if (t > cap) t = cap;
      if (t > base) t = t - 1;
      else          t = base;
      return t;
   endfunction

   // Width needed for a sum of n values each below 2**w.
   function automatic int unsigned lls_sum_width(input int unsigned w, input int unsigned n);
      return w + $clog2(n) + 1;
   endfunction

endpackage

// File: rtl/lls_score_bank.sv
module lls_score_bank #(
   parameter int unsigned NUM_WF  = 8,
   parameter int unsigned SCORE_W = 10,
   parameter int unsigned BASE    = 16,
   parameter int unsigned INC     = 64,
   parameter int unsigned CAP     = 1000
) (
   input  logic                               clk_i,
   input  logic                               rst_ni,
   input  logic                               launch_i,
   input  logic                               hit_vld_i,
   input  logic [$clog2(NUM_WF)-1:0]          hit_wid_i,
   output logic [NUM_WF-1:0][SCORE_W-1:0]     score_o
);
   localparam int unsigned WID_W = $clog2(NUM_WF);
   localparam logic [SCORE_W-1:0] BASE_V = SCORE_W'(BASE);

   logic [NUM_WF-1:0]              hit_dec;
   logic [NUM_WF-1:0][SCORE_W-1:0] score_q;
   logic [NUM_WF-1:0][SCORE_W-1:0] score_d;

   for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
      assign hit_dec[w] = hit_vld_i && (hit_wid_i == WID_W'(w));

      always_comb begin
         if (launch_i) score_d[w] = BASE_V;
         else          score_d[w] = SCORE_W'(lls_pkg::lls_step(32'(score_q[w]), hit_dec[w], INC, CAP, BASE));
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) score_q[w] <= BASE_V;
         else         score_q[w] <= score_d[w];
      end
   end

   assign score_o = score_q;
endmodule

// File: rtl/lls_rank_matrix.sv
module lls_rank_matrix #(
   parameter int unsigned NUM_WF  = 8,
   parameter int unsigned SCORE_W = 10
) (
   input  logic [NUM_WF-1:0][SCORE_W-1:0] score_i,
   // ahead_o[i][j] = 1 when wavefront j is ordered before wavefront i
   output logic [NUM_WF-1:0][NUM_WF-1:0]  ahead_o
);
   for (genvar i = 0; i < NUM_WF; i++) begin : g_row
      for (genvar j = 0; j < NUM_WF; j++) begin : g_col
         if (i == j) begin : g_self
            assign ahead_o[i][j] = 1'b0;
         end else if (j < i) begin : g_lower_id
            // lower ID wins ties
            assign ahead_o[i][j] = (score_i[j] >= score_i[i]);
         end else begin : g_higher_id
            assign ahead_o[i][j] = (score_i[j] > score_i[i]);
         end
      end
   end
endmodule

// File: rtl/lls_cutoff_gate.sv
module lls_cutoff_gate #(
   parameter int unsigned NUM_WF  = 8,
   parameter int unsigned SCORE_W = 10,
   parameter int unsigned SUM_W   = 14,
   parameter int unsigned CUTOFF  = 128
) (
   input  logic [NUM_WF-1:0][SCORE_W-1:0] score_i,
   input  logic [NUM_WF-1:0][NUM_WF-1:0]  ahead_i,
   input  logic [NUM_WF-1:0]              load_req_i,
   output logic [NUM_WF-1:0]              can_issue_o
);
   localparam logic [SUM_W-1:0] CUT_V = SUM_W'(CUTOFF);

   for (genvar i = 0; i < NUM_WF; i++) begin : g_wf
      logic [SUM_W-1:0] run_sum;
      logic             over_cut;
      logic             is_first;

      always_comb begin
         run_sum = SUM_W'(score_i[i]);
         for (int j = 0; j < NUM_WF; j++) begin
            if (ahead_i[i][j]) run_sum = run_sum + SUM_W'(score_i[j]);
         end
      end

      assign over_cut       = (run_sum > CUT_V);
      assign is_first       = ~|ahead_i[i];
      assign can_issue_o[i] = ~(load_req_i[i] & over_cut & ~is_first);
   end
endmodule

// File: rtl/lls_throttle_unit.sv
module lls_throttle_unit #(
   parameter int unsigned NUM_WF  = 8,
   parameter int unsigned SCORE_W = 10,
   parameter int unsigned BASE    = 16,
   parameter int unsigned INC     = 64,
   parameter int unsigned CAP     = 1000,
   parameter int unsigned CUTOFF  = NUM_WF * BASE
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      launch_i,
   input  logic                      hit_vld_i,
   input  logic [$clog2(NUM_WF)-1:0] hit_wid_i,
   input  logic [NUM_WF-1:0]         load_req_i,
   output logic [NUM_WF-1:0]         can_issue_o
);
   localparam int unsigned SUM_W = lls_pkg::lls_sum_width(SCORE_W, NUM_WF);

   initial begin
      if (NUM_WF < 2)                 $fatal(1, "NUM_WF must be at least 2");
      if (BASE < 1)                   $fatal(1, "BASE must be at least 1");
      if (CAP <= BASE)                $fatal(1, "CAP must exceed BASE");
      if (CAP >= (1 << SCORE_W))      $fatal(1, "CAP does not fit SCORE_W");
      if (CUTOFF >= (1 << (SUM_W-1))) $fatal(1, "CUTOFF does not fit the sum width");
   end

   logic [NUM_WF-1:0][SCORE_W-1:0] score_q;
   logic [NUM_WF-1:0][NUM_WF-1:0]  ahead;

   lls_score_bank #(
      .NUM_WF(NUM_WF), .SCORE_W(SCORE_W), .BASE(BASE), .INC(INC), .CAP(CAP)
   ) bank_i (
      .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch_i),
      .hit_vld_i(hit_vld_i), .hit_wid_i(hit_wid_i), .score_o(score_q)
   );

   lls_rank_matrix #(
      .NUM_WF(NUM_WF), .SCORE_W(SCORE_W)
   ) rank_i (
      .score_i(score_q), .ahead_o(ahead)
   );

   lls_cutoff_gate #(
      .NUM_WF(NUM_WF), .SCORE_W(SCORE_W), .SUM_W(SUM_W), .CUTOFF(CUTOFF)
   ) gate_i (
      .score_i(score_q), .ahead_i(ahead), .load_req_i(load_req_i),
      .can_issue_o(can_issue_o)
   );
endmodule

// File: rtl/lls_throttle_checker.sv
module lls_throttle_checker #(
   parameter int unsigned NUM_WF  = 8,
   parameter int unsigned SCORE_W = 10,
   parameter int unsigned BASE    = 16,
   parameter int unsigned INC     = 64,
   parameter int unsigned CAP     = 1000
) (
   input logic                              clk_i,
   input logic                              rst_ni,
   input logic                              launch_i,
   input logic                              hit_vld_i,
   input logic [$clog2(NUM_WF)-1:0]         hit_wid_i,
   input logic [NUM_WF-1:0]                 load_req_i,
   input logic [NUM_WF-1:0]                 can_issue_o,
   input logic [NUM_WF-1:0][SCORE_W-1:0]    score_q
);
   localparam int unsigned WID_W = $clog2(NUM_WF);

   // R6: no load request, no throttling
   a_r6_non_load_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (~load_req_i & ~can_issue_o) == '0);

   // R7: the first-ordered wavefront always keeps permission
   a_r7_first_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      can_issue_o != '0);

   // R1: launch returns every score to base
   a_r1_launch_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
      launch_i |=> (score_q == {NUM_WF{SCORE_W'(BASE)}}));

   for (genvar w = 0; w < NUM_WF; w++) begin : g_wf
      logic hit_w;
      assign hit_w = hit_vld_i && (hit_wid_i == WID_W'(w));

      // R3: decay by one above base
      a_r3_decay: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!launch_i && !hit_w && score_q[w] > SCORE_W'(BASE))
         |=> score_q[w] == $past(score_q[w]) - SCORE_W'(1));

      // R3: base is a floor
      a_r3_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!launch_i && !hit_w && score_q[w] == SCORE_W'(BASE))
         |=> score_q[w] == SCORE_W'(BASE));

      // R2: hit adds INC, then decay takes one
      a_r2_hit_add: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!launch_i && hit_w && (32'(score_q[w]) + INC <= CAP))
         |=> score_q[w] == $past(score_q[w]) + SCORE_W'(INC - 1));

      // R9: saturation at the cap
      a_r9_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!launch_i && hit_w && (32'(score_q[w]) + INC > CAP))
         |=> score_q[w] == SCORE_W'(CAP - 1));
   end
endmodule

bind lls_throttle_unit lls_throttle_checker #(
   .NUM_WF(NUM_WF), .SCORE_W(SCORE_W), .BASE(BASE), .INC(INC), .CAP(CAP)
) chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch_i), .hit_vld_i(hit_vld_i),
   .hit_wid_i(hit_wid_i), .load_req_i(load_req_i), .can_issue_o(can_issue_o),
   .score_q(score_q)
);

// File: tb/lls_throttle_unit_tb_top.sv
module lls_throttle_unit_tb_top;
   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned NWF  = 8;
   localparam int unsigned SW   = 10;
   localparam int unsigned BASE = 16;
   localparam int unsigned INC  = 64;
   localparam int unsigned CAP  = 1000;
   localparam int unsigned CUT  = NWF * BASE;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           launch = 1'b0;
   logic           hit_vld = 1'b0;
   logic [2:0]     hit_wid = '0;
   logic [NWF-1:0] load_req = '0;
   logic [NWF-1:0] can_issue;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   int unsigned ms [NWF];

   always #(CLK_PERIOD/2) clk = ~clk;

   lls_throttle_unit #(
      .NUM_WF(NWF), .SCORE_W(SW), .BASE(BASE), .INC(INC), .CAP(CAP), .CUTOFF(CUT)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .launch_i(launch), .hit_vld_i(hit_vld),
      .hit_wid_i(hit_wid), .load_req_i(load_req), .can_issue_o(can_issue)
   );

   // Expected permission from the model scores (R4, R5, R6, R7)
   function automatic logic [NWF-1:0] exp_can(input logic [NWF-1:0] lr);
      logic [NWF-1:0] r;
      for (int i = 0; i < NWF; i++) begin
         int unsigned acc;
         int unsigned n_ahead;
         acc = ms[i];
         n_ahead = 0;
         for (int j = 0; j < NWF; j++) begin
            if (j != i && (ms[j] > ms[i] || (ms[j] == ms[i] && j < i))) begin
               acc += ms[j];
               n_ahead++;
            end
         end
         r[i] = !(lr[i] && n_ahead != 0 && acc > CUT);
      end
      return r;
   endfunction

   // Model score evolution (R1, R2, R3, R9)
   task automatic model_update(input bit lau, input bit hv, input int unsigned wid);
      for (int w = 0; w < NWF; w++) begin
         int unsigned t;
         if (lau) ms[w] = BASE;
         else begin
            t = ms[w];
            if (hv && wid == w) t = t + INC;
            if (t > CAP) t = CAP;
            ms[w] = (t > BASE) ? t - 1 : BASE;
         end
      end
   endtask

   task automatic step(input bit lau, input bit hv, input logic [2:0] wid,
                       input logic [NWF-1:0] lr, input string tag);
      logic [NWF-1:0] e;
      @(negedge clk);
      launch = lau; hit_vld = hv; hit_wid = wid; load_req = lr;
      #1;
      e = exp_can(lr);
      n_checks++;
      if (can_issue !== e) begin
         n_errors++;
         $display("FAIL %s can_issue=%h expected=%h", tag, can_issue, e);
      end
      @(posedge clk);
      model_update(lau, hv, int'(wid));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int w = 0; w < NWF; w++) ms[w] = BASE;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, every wavefront may load
      step(0, 0, 3'd0, 8'hFF, "R1 reset");
      // R6: no loads requested
      step(0, 0, 3'd0, 8'h00, "R6 idle");
      // R2: single hit on wf3
      step(0, 1, 3'd3, 8'hFF, "R2 hit");
      // R4 R5: wf3 first, base ties by ascending ID, wf4..7 throttled
      step(0, 0, 3'd0, 8'hFF, "R4 R5 tie order");
      // R8: same-cycle response to a partial request vector
      step(0, 0, 3'd0, 8'hA0, "R8 partial");
      step(0, 0, 3'd0, 8'h0F, "R6 R8 low half");
      // R9: saturate wf0
      for (int k = 0; k < 20; k++) step(0, 1, 3'd0, 8'hFF, "R9 saturate");
      // R7: wf0 alone over the cutoff still loads
      step(0, 0, 3'd0, 8'h01, "R7 first kept");
      // R3: long decay back toward base
      for (int k = 0; k < 1000; k++) step(0, 0, 3'd0, 8'(($urandom % 256)), "R3 decay");
      // R1: launch together with a hit; launch wins
      step(0, 1, 3'd5, 8'hFF, "R2 pre-launch");
      step(1, 1, 3'd2, 8'hFF, "R1 launch");
      step(0, 0, 3'd0, 8'hFF, "R1 after launch");
      // Random mix
      for (int k = 0; k < 3000; k++) begin
         bit lau;
         bit hv;
         lau = ($urandom % 500) == 0;
         hv  = ($urandom % 8) == 0;
         step(lau, hv, 3'($urandom % 8), 8'($urandom % 256), "RND R2 R3 R4 R5");
      end

      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end
endmodule